// File: doc/BRIEF.md
# Exception Entry Controller

This block makes the single-edge architectural state change that a 32-bit RISC core performs when it enters an exception handler. In each cycle it looks at an explicit exception request with its 4-bit code, and at two interrupt lines: one from external devices and one from the tick timer. Each interrupt line is gated by its enable bit in the live status word. From these it picks at most one cause. On the next clock edge it loads registered copies of the handler address and the saved return address. It also loads the saved status, the faulting address, and the modified status and power-management words.

The core keeps its live PC, status, power-management and vector-base values elsewhere and presents them on the inputs. It copies the registered results back when it sees the one-cycle flush pulse. Together with that pulse the block also issues two more pulses: one clears the core's delay-slot flag and one drops any load-linked reservation. An out-of-range code does not change any register. It is reported through an error pulse instead.

Top module: `exc_entry_ctrl`

## Requirements
- R1: During reset every output is zero.
- R2: If a cause with a valid code (1 to 14) is taken in a cycle, then after the next clock edge `flush_o` and `resv_inval_o` are high for one cycle. In that cycle `new_pc_o` holds the code shifted left by 8, for example 0x500 for the tick code 5.
- R3: The handler address is OR-ed with `evbar_i` when `evbar_present_i` is high. It is OR-ed with 0xF0000000 when bit 14 of `sr_i` (high-vector select) is set.
- R4: With `dslot_i` low, `epcr_o` receives `pc_i`. For system call (code 0xC) and floating point (code 0xD) it receives `pc_i` + 4 instead.
- R5: With `dslot_i` high, `epcr_o` receives `pc_i` - 4, bit 13 of `sr_o` (delay-slot exception) is set, and `dslot_clr_o` pulses. With `dslot_i` low, bit 13 of `sr_o` is cleared and `dslot_clr_o` stays low.
- R6: `esr_o` receives the whole `sr_i` value from before the exception.
- R7: `sr_o` is `sr_i` with bit 0 (supervisor) set and with bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable) and 6 (instruction MMU enable) cleared. Bit 13 follows R5 and all other bits are unchanged.
- R8: `pmr_o` is `pmr_i` with bits 4 (doze enable) and 5 (sleep enable) cleared and all other bits unchanged.
- R9: `eear_o` receives `pc_i` only for the illegal-instruction code 7. For every other code it keeps its value.
- R10: The device interrupt is taken only when bit 2 of `sr_i` is set, and uses code 8. The tick interrupt is taken only when bit 1 is set, and uses code 5. When both are pending and enabled, the tick interrupt is taken.
- R11: An explicit request on `exc_req_i` takes precedence over both interrupt lines.
- R12: A taken code of 0 or 15 raises `bad_code_o` for one cycle after the edge. It leaves every registered output unchanged and raises no other pulse.
- R13: In a cycle with no request and no enabled pending interrupt, the outputs hold and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 1 | Explicit exception request |
| exc_code_i | input | 4 | Code of the explicit request |
| irq_dev_i | input | 1 | Pending external-device interrupt |
| irq_tick_i | input | 1 | Pending tick-timer interrupt |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| pmr_i | input | 32 | Current power-management word |
| evbar_i | input | 32 | Vector base |
| evbar_present_i | input | 1 | Vector base in use |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| flush_o | output | 1 | One-cycle pipeline flush, results valid |
| new_pc_o | output | 32 | Handler address |
| epcr_o | output | 32 | Saved return address |
| esr_o | output | 32 | Saved status word |
| eear_o | output | 32 | Faulting effective address |
| sr_o | output | 32 | Modified status word |
| pmr_o | output | 32 | Modified power-management word |
| dslot_clr_o | output | 1 | Clear the core's delay-slot flag |
| resv_inval_o | output | 1 | Drop the load-linked reservation |
| bad_code_o | output | 1 | Out-of-range code taken |

## Verification
The bench drives explicit requests with plain codes, with the vector base and the high-vector bit in each combination, and with the codes that move the return address forward. The same codes are repeated with the delay-slot flag set, which separates the three return-address rules. The interrupt lines are driven alone, together, masked and alongside a request; this separates the enable gating, the tick-over-device order and the request precedence. Status and power words of all ones and all zeros show which bits are forced and which pass through. Out-of-range codes and idle cycles placed after known state show whether anything moved.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int EXC_CODE_W = 4;

   localparam logic [3:0] EXC_RESET    = 4'h1;
   localparam logic [3:0] EXC_BUSERR   = 4'h2;
   localparam logic [3:0] EXC_DPAGE    = 4'h3;
   localparam logic [3:0] EXC_IPAGE    = 4'h4;
   localparam logic [3:0] EXC_TICK     = 4'h5;
   localparam logic [3:0] EXC_ALIGN    = 4'h6;
   localparam logic [3:0] EXC_ILLEGAL  = 4'h7;
   localparam logic [3:0] EXC_DEVICE   = 4'h8;
   localparam logic [3:0] EXC_DTLB     = 4'h9;
   localparam logic [3:0] EXC_ITLB     = 4'hA;
   localparam logic [3:0] EXC_RANGE    = 4'hB;
   localparam logic [3:0] EXC_SYSCALL  = 4'hC;
   localparam logic [3:0] EXC_FPU      = 4'hD;
   localparam logic [3:0] EXC_TRAP     = 4'hE;
   localparam logic [3:0] EXC_LAST     = EXC_TRAP;

   // status word bit positions decoded by the core
   localparam int ST_SUPER    = 0;
   localparam int ST_TICK_EN  = 1;
   localparam int ST_IRQ_EN   = 2;
   localparam int ST_DMMU_EN  = 5;
   localparam int ST_IMMU_EN  = 6;
   localparam int ST_DSLOT_EX = 13;
   localparam int ST_HIGH_VEC = 14;

   // power-management word bit positions
   localparam int PM_DOZE     = 4;
   localparam int PM_SLEEP    = 5;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_REQ,
      SRC_TICK,
      SRC_DEV
   } exc_src_e;

endpackage

// File: rtl/exc_src_arb.sv
module exc_src_arb
   import exc_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              irq_dev_i,
   input  logic              irq_tick_i,
   input  logic              irq_en_i,
   input  logic              tick_en_i,
   output logic              take_o,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o,
   output exc_src_e          src_o
);

   localparam logic [CODE_W-1:0] CodeTick = CODE_W'(EXC_TICK);
   localparam logic [CODE_W-1:0] CodeDev  = CODE_W'(EXC_DEVICE);
   localparam logic [CODE_W-1:0] CodeLast = CODE_W'(EXC_LAST);

   logic tick_live, dev_live;

   assign tick_live = irq_tick_i && tick_en_i;
   assign dev_live  = irq_dev_i && irq_en_i;

   always_comb begin
      src_o  = SRC_NONE;
      code_o = '0;
      if (req_i) begin
         src_o  = SRC_REQ;
         code_o = code_i;
      end else if (tick_live) begin
         src_o  = SRC_TICK;
         code_o = CodeTick;
      end else if (dev_live) begin
         src_o  = SRC_DEV;
         code_o = CodeDev;
      end
   end

   assign take_o  = (src_o != SRC_NONE);
   assign valid_o = take_o && (code_o != '0) && (code_o <= CodeLast);

   // R10: an enabled tick beats an enabled device line
   p_tick_wins_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_i && irq_tick_i && tick_en_i) |-> (code_o == CodeTick));

   // R11: an explicit request always carries its own code
   p_req_first_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |-> (code_o == code_i));

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
   import exc_pkg::*;
#(
   parameter int                XLEN        = 32,
   parameter int                CODE_W      = 4,
   parameter int                VEC_SHIFT   = 8,
   parameter logic [XLEN-1:0]   HIGH_PREFIX = 'hF000_0000,
   parameter bit                HAS_BASE    = 1'b1
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              dslot_i,
   input  logic              high_vec_i,
   input  logic [XLEN-1:0]   base_i,
   input  logic              base_present_i,
   output logic [XLEN-1:0]   vec_pc_o,
   output logic [XLEN-1:0]   save_pc_o
);

   localparam logic [XLEN-1:0] InstrBytes = XLEN'(4);

   logic [XLEN-1:0] offset;
   logic [XLEN-1:0] base_term;
   logic [XLEN-1:0] high_term;
   logic            step_over;

   assign offset = XLEN'(code_i) << VEC_SHIFT;

   generate
      if (HAS_BASE) begin : g_base
         assign base_term = base_present_i ? base_i : '0;
      end else begin : g_no_base
         assign base_term = '0;
      end
   endgenerate

   assign high_term = high_vec_i ? HIGH_PREFIX : '0;
   assign vec_pc_o  = offset | base_term | high_term;

   assign step_over = (code_i == CODE_W'(EXC_SYSCALL)) || (code_i == CODE_W'(EXC_FPU));

   always_comb begin
      if (dslot_i)        save_pc_o = pc_i - InstrBytes;
      else if (step_over) save_pc_o = pc_i + InstrBytes;
      else                save_pc_o = pc_i;
   end

endmodule

// File: rtl/exc_stat_upd.sv
module exc_stat_upd
   import exc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] sr_i,
   input  logic [XLEN-1:0] pmr_i,
   input  logic            dslot_i,
   output logic [XLEN-1:0] sr_o,
   output logic [XLEN-1:0] pmr_o
);

   generate
      for (genvar b = 0; b < XLEN; b++) begin : g_sr_bit
         if (b == ST_SUPER) begin : g_set
            assign sr_o[b] = 1'b1;
         end else if (b == ST_TICK_EN || b == ST_IRQ_EN ||
                      b == ST_DMMU_EN || b == ST_IMMU_EN) begin : g_clr
            assign sr_o[b] = 1'b0;
         end else if (b == ST_DSLOT_EX) begin : g_ds
            assign sr_o[b] = dslot_i;
         end else begin : g_keep
            assign sr_o[b] = sr_i[b];
         end
      end

      for (genvar b = 0; b < XLEN; b++) begin : g_pm_bit
         if (b == PM_DOZE || b == PM_SLEEP) begin : g_clr
            assign pmr_o[b] = 1'b0;
         end else begin : g_keep
            assign pmr_o[b] = pmr_i[b];
         end
      end
   endgenerate

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              CODE_W      = 4,
   parameter int              VEC_SHIFT   = 8,
   parameter logic [XLEN-1:0] HIGH_PREFIX = 'hF000_0000,
   parameter bit              HAS_BASE    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              exc_req_i,
   input  logic [CODE_W-1:0] exc_code_i,
   input  logic              irq_dev_i,
   input  logic              irq_tick_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   sr_i,
   input  logic [XLEN-1:0]   pmr_i,
   input  logic [XLEN-1:0]   evbar_i,
   input  logic              evbar_present_i,
   input  logic              dslot_i,
   output logic              flush_o,
   output logic [XLEN-1:0]   new_pc_o,
   output logic [XLEN-1:0]   epcr_o,
   output logic [XLEN-1:0]   esr_o,
   output logic [XLEN-1:0]   eear_o,
   output logic [XLEN-1:0]   sr_o,
   output logic [XLEN-1:0]   pmr_o,
   output logic              dslot_clr_o,
   output logic              resv_inval_o,
   output logic              bad_code_o
);

   localparam int MinXlen = VEC_SHIFT + CODE_W;

   generate
      if (XLEN < MinXlen) begin : g_chk_xlen
         $error("XLEN too narrow for shifted exception code");
      end
      if (CODE_W < EXC_CODE_W) begin : g_chk_code
         $error("CODE_W cannot hold every exception code");
      end
      if (XLEN <= ST_HIGH_VEC) begin : g_chk_sr
         $error("XLEN too narrow for status bit layout");
      end
   endgenerate

   logic              take, valid;
   logic [CODE_W-1:0] sel_code;
   exc_src_e          src;
   logic [XLEN-1:0]   vec_pc, save_pc, sr_next, pmr_next;
   logic              is_illegal;

   exc_src_arb #(.CODE_W(CODE_W)) i_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (exc_req_i),
      .code_i     (exc_code_i),
      .irq_dev_i  (irq_dev_i),
      .irq_tick_i (irq_tick_i),
      .irq_en_i   (sr_i[ST_IRQ_EN]),
      .tick_en_i  (sr_i[ST_TICK_EN]),
      .take_o     (take),
      .valid_o    (valid),
      .code_o     (sel_code),
      .src_o      (src)
   );

   exc_vec_gen #(
      .XLEN        (XLEN),
      .CODE_W      (CODE_W),
      .VEC_SHIFT   (VEC_SHIFT),
      .HIGH_PREFIX (HIGH_PREFIX),
      .HAS_BASE    (HAS_BASE)
   ) i_vec (
      .code_i         (sel_code),
      .pc_i           (pc_i),
      .dslot_i        (dslot_i),
      .high_vec_i     (sr_i[ST_HIGH_VEC]),
      .base_i         (evbar_i),
      .base_present_i (evbar_present_i),
      .vec_pc_o       (vec_pc),
      .save_pc_o      (save_pc)
   );

   exc_stat_upd #(.XLEN(XLEN)) i_stat (
      .sr_i    (sr_i),
      .pmr_i   (pmr_i),
      .dslot_i (dslot_i),
      .sr_o    (sr_next),
      .pmr_o   (pmr_next)
   );

   assign is_illegal = (sel_code == CODE_W'(EXC_ILLEGAL));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         flush_o      <= 1'b0;
         new_pc_o     <= '0;
         epcr_o       <= '0;
         esr_o        <= '0;
         eear_o       <= '0;
         sr_o         <= '0;
         pmr_o        <= '0;
         dslot_clr_o  <= 1'b0;
         resv_inval_o <= 1'b0;
         bad_code_o   <= 1'b0;
      end else begin
         flush_o      <= valid;
         resv_inval_o <= valid;
         dslot_clr_o  <= valid && dslot_i;
         bad_code_o   <= take && !valid;
         if (valid) begin
            new_pc_o <= vec_pc;
            epcr_o   <= save_pc;
            esr_o    <= sr_i;
            sr_o     <= sr_next;
            pmr_o    <= pmr_next;
            if (is_illegal) eear_o <= pc_i;
         end
      end
   end

   // R7: a flushed entry always lands in supervisor mode with both interrupt enables off
   p_super_entry_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> (sr_o[ST_SUPER] && !sr_o[ST_IRQ_EN] && !sr_o[ST_TICK_EN]));

   // R5: delay-slot status bit mirrors the flag sampled on the entry edge
   p_dsx_track_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> (sr_o[ST_DSLOT_EX] == $past(dslot_i)));

   // R6: saved status equals the status presented on the entry edge
   p_esr_capture_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> (esr_o == $past(sr_i)));

   // R12: a bad code disturbs no register and raises no flush
   p_bad_holds_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_code_o |-> (!flush_o && !resv_inval_o && $stable(new_pc_o) &&
                      $stable(sr_o) && $stable(epcr_o)));

   // R2: flush and reservation drop always travel together
   p_pulse_pair_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> resv_inval_o);

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [3:0]  code = '0;
   logic        dev = 1'b0, tick = 1'b0;
   logic [31:0] pc = '0, sr = '0, pmr = '0, base = '0;
   logic        bp = 1'b0, ds = 1'b0;

   logic        flush, dclr, resv, bad;
   logic [31:0] npc, epcr, esr, eear, sro, pmro;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   exc_entry_ctrl i_exc_entry_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .exc_req_i(req), .exc_code_i(code),
      .irq_dev_i(dev), .irq_tick_i(tick), .pc_i(pc), .sr_i(sr), .pmr_i(pmr),
      .evbar_i(base), .evbar_present_i(bp), .dslot_i(ds),
      .flush_o(flush), .new_pc_o(npc), .epcr_o(epcr), .esr_o(esr),
      .eear_o(eear), .sr_o(sro), .pmr_o(pmro), .dslot_clr_o(dclr),
      .resv_inval_o(resv), .bad_code_o(bad)
   );

   typedef struct {
      string       tag;
      logic        flush, resv, dclr, bad;
      logic [31:0] npc, epcr, esr, eear, sr, pmr;
   } exp_t;

   exp_t q[$];

   // reference model state
   logic [31:0] m_npc = '0, m_epcr = '0, m_esr = '0, m_eear = '0, m_sr = '0, m_pmr = '0;

   task automatic cmp(string tag, string fld, logic [31:0] got, logic [31:0] exp);
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, fld, got, exp);
      end
   endtask

   task automatic step(input logic r, input logic [3:0] c, input logic d, input logic t,
                       input logic [31:0] p, input logic [31:0] s, input logic [31:0] pm,
                       input logic [31:0] b, input logic bpres, input logic dsl,
                       input string tag);
      exp_t e;
      int   sel;
      bit   ok;
      @(negedge clk);
      req = r; code = c; dev = d; tick = t; pc = p; sr = s; pmr = pm;
      base = b; bp = bpres; ds = dsl;
      sel = -1;
      if (r)                  sel = c;
      else if (t && s[1])     sel = 5;
      else if (d && s[2])     sel = 8;
      ok = (sel >= 1 && sel <= 14);
      e.tag = tag;
      e.flush = ok; e.resv = ok; e.dclr = ok && dsl;
      e.bad = (sel >= 0) && !ok;
      if (ok) begin
         m_npc = (32'(sel) * 256) | (bpres ? b : 32'h0) | (s[14] ? 32'hF000_0000 : 32'h0);
         if (dsl)                      m_epcr = p - 32'd4;
         else if (sel == 12 || sel == 13) m_epcr = p + 32'd4;
         else                          m_epcr = p;
         m_esr = s;
         if (sel == 7) m_eear = p;
         m_sr = (s & ~32'h0000_2066) | 32'h1 | (dsl ? 32'h2000 : 32'h0);
         m_pmr = pm & ~32'h30;
      end
      e.npc = m_npc; e.epcr = m_epcr; e.esr = m_esr; e.eear = m_eear;
      e.sr = m_sr; e.pmr = m_pmr;
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, tag);
   endtask

   // monitor: results of the edge at t appear by t+5
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            cmp(e.tag, "flush", 32'(flush), 32'(e.flush));
            cmp(e.tag, "resv",  32'(resv),  32'(e.resv));
            cmp(e.tag, "dclr",  32'(dclr),  32'(e.dclr));
            cmp(e.tag, "bad",   32'(bad),   32'(e.bad));
            cmp(e.tag, "new_pc", npc,  e.npc);
            cmp(e.tag, "epcr",   epcr, e.epcr);
            cmp(e.tag, "esr",    esr,  e.esr);
            cmp(e.tag, "eear",   eear, e.eear);
            cmp(e.tag, "sr",     sro,  e.sr);
            cmp(e.tag, "pmr",    pmro, e.pmr);
         end
      end
   end

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      // R1: reset state
      n_cmp++;
      if ({flush, resv, dclr, bad} !== 4'b0 || npc !== 0 || epcr !== 0 || esr !== 0 ||
          eear !== 0 || sro !== 0 || pmro !== 0) begin
         n_bad++;
         $display("FAIL R1 reset: got nonzero output expected all zero");
      end
      @(negedge clk); rst_n = 1'b1;

      idle("R13 idle after reset");
      // R2 plain trap
      step(1, 4'hE, 0, 0, 32'h0000_1000, 32'h0000_8000, 32'h0, 32'h0, 0, 0, "R2 trap vector");
      idle("R13 hold after trap");
      // R3 base, high page, both, base ignored when absent
      step(1, 4'h2, 0, 0, 32'h0000_2000, 32'h0, 32'h0, 32'h0010_0000, 1, 0, "R3 base or");
      step(1, 4'h3, 0, 0, 32'h0000_2004, 32'h0000_4000, 32'h0, 32'h0010_0000, 0, 0, "R3 high prefix");
      step(1, 4'h4, 0, 0, 32'h0000_2008, 32'h0000_4000, 32'h0, 32'h0020_0000, 1, 0, "R3 base and high");
      // R4 return address rules
      step(1, 4'hC, 0, 0, 32'h0000_3000, 32'h0, 32'h0, 32'h0, 0, 0, "R4 syscall plus4");
      step(1, 4'hD, 0, 0, 32'h0000_3100, 32'h0, 32'h0, 32'h0, 0, 0, "R4 fpu plus4");
      step(1, 4'h6, 0, 0, 32'h0000_3200, 32'h0, 32'h0, 32'h0, 0, 0, "R4 align unchanged");
      // R5 delay slot
      step(1, 4'hC, 0, 0, 32'h0000_4000, 32'h0, 32'h0, 32'h0, 0, 1, "R5 dslot syscall minus4");
      step(1, 4'h9, 0, 0, 32'h0000_4100, 32'h0000_2000, 32'h0, 32'h0, 0, 0, "R5 dsx cleared");
      // R6 R7 R8 all-ones and all-zeros words
      step(1, 4'hB, 0, 0, 32'h0000_5000, 32'hFFFF_BFFF, 32'hFFFF_FFFF, 32'h0, 0, 0, "R6 R7 R8 ones");
      step(1, 4'hA, 0, 0, 32'h0000_5100, 32'h0, 32'h0, 32'h0, 0, 1, "R6 R7 R8 zeros");
      // R9 faulting address only for illegal
      step(1, 4'h7, 0, 0, 32'h0000_6000, 32'h0, 32'h0, 32'h0, 0, 0, "R9 illegal loads eear");
      step(1, 4'h1, 0, 0, 32'h0000_6100, 32'h0, 32'h0, 32'h0, 0, 0, "R9 eear holds");
      // R10 interrupt gating and order
      step(0, 4'h0, 1, 0, 32'h0000_7000, 32'h0000_0002, 32'h0, 32'h0, 0, 0, "R10 dev masked");
      step(0, 4'h0, 0, 1, 32'h0000_7004, 32'h0000_0004, 32'h0, 32'h0, 0, 0, "R10 tick masked");
      step(0, 4'h0, 1, 0, 32'h0000_7008, 32'h0000_0004, 32'h0, 32'h0, 0, 0, "R10 dev taken");
      step(0, 4'h0, 0, 1, 32'h0000_700C, 32'h0000_0002, 32'h0, 32'h0, 0, 0, "R10 tick taken");
      step(0, 4'h0, 1, 1, 32'h0000_7010, 32'h0000_0006, 32'h0, 32'h0, 0, 0, "R10 tick beats dev");
      step(0, 4'h0, 1, 1, 32'h0000_7014, 32'h0000_0004, 32'h0, 32'h0, 0, 0, "R10 dev when tick masked");
      // R11 request precedence
      step(1, 4'h3, 1, 1, 32'h0000_8000, 32'h0000_0006, 32'h0, 32'h0, 0, 0, "R11 request first");
      // R12 bad codes
      step(1, 4'h0, 0, 0, 32'h0000_9000, 32'h0000_4000, 32'hFF, 32'h0, 0, 1, "R12 code zero");
      step(1, 4'hF, 1, 1, 32'h0000_9004, 32'h0000_0006, 32'hFF, 32'h0, 0, 1, "R12 code fifteen");
      // R13 nothing pending after bad code
      step(0, 4'h0, 0, 0, 32'h0000_9008, 32'h0000_0006, 32'hFF, 32'h0, 0, 1, "R13 idle hold");
      idle("R13 final idle");
      repeat (3) @(posedge clk);
      #6;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule